// File: doc/BRIEF.md
# Learning-Based DRAM Command Selector

This block decides, once per scheduling cycle, which type of DRAM command a memory controller should issue next. It acts as a table-driven reinforcement-learning agent. The surrounding controller supplies a 6-bit quantized state index and a 7-bit mask of command types that the timing checks currently allow. The block keeps a signed fixed-point value estimate for every (state, action) pair. It normally issues the allowed action with the highest estimate. About one decision in 64 it explores instead, taking a pseudo-random allowed action.

Learning happens online and there is no separate training phase. Issuing a read or a write earns a reward. On every decision the block updates the estimate of the pair it used on the previous decision. The update uses that reward and the estimate of the pair it has just chosen, so the policy drifts towards whichever commands lead to data transfers. Request queueing, timing legality, address mapping and the data path all sit outside the block.

Top module: `qlearn_cmd_sel`

## Requirements
- R1: Actions are encoded on `cmd_o` as 0 activate, 1 write, 2 read for a load miss, 3 read for a store miss, 4 precharge for a waiting request, 5 early precharge, 6 no-operation. In a decision cycle (`step_i` high) `cmd_valid_o` is 1 and `cmd_o` is below 7. Outside a decision cycle `cmd_valid_o` is 0. `cmd_o` is combinational from the current inputs and table.
- R2: The chosen action is always one whose bit is set in `legal_i`, or no-operation. Bit 6 of `legal_i` is ignored, because no-operation is always allowed.
- R3: On a greedy decision the block issues the allowed action with the largest signed value for the current state. When several allowed actions share that value, the lowest index wins.
- R4: Reset loads every table entry with `INIT_Q` (default 4096, that is 16.0 with 8 fraction bits), clears the previous-decision record, and loads the LFSR with `LFSR_SEED`. With all actions allowed and no exploration, the first decision after reset is therefore action 0.
- R5: The reward for a decision is 2^FRAC_W (1.0) when the action issued was 1, 2 or 3, and 0 for every other action.
- R6: At the clock edge that ends each decision cycle after the first one since reset, the entry of the previous decision (s,a) becomes Q + ((r + Qn − (Qn>>>GAMMA_SH)) − Q)>>>ALPHA_SH. Here r is the reward of the previous action and Qn is the value, before this edge, of the pair chosen now. The result saturates to the signed VAL_W range.
- R7: A cycle with `step_i` low changes no table entry, leaves the previous-decision record as it was, and does not advance the LFSR.
- R8: A 16-bit LFSR shifts left on each decision cycle, taking in the feedback bit b15^b13^b12^b10 at bit 0. A decision explores when LFSR bits 5:0 are all zero. It then starts from index b15:b13 (7 maps to 0) and takes the first allowed action at or after that index, wrapping from 6 back to 0.
- R9: When `legal_i[5:0]` is zero, the block issues no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Decision cycle strobe |
| state_i | input | STATE_W | Quantized state index |
| legal_i | input | 7 | Allowed-action mask, bit n is action n |
| cmd_valid_o | output | 1 | A decision is presented this cycle |
| cmd_o | output | 3 | Chosen action code |

## Verification
The assertions assume that `state_i` and `legal_i` are settled before each rising edge and stay steady through any cycle in which `step_i` is high. They also assume that the mask's low six bits may take any value, including zero. The bench changes every input only on the falling edge. It mixes unconstrained masks, masks that allow only no-operation, masks with only bit 6 set, and idle gaps that carry random state and mask values. That covers the tie, exploration and hold cases, and every stimulus stays inside those assumptions.

// File: rtl/qsel_pkg.sv
package qsel_pkg;
  localparam int NUM_ACT = 7;
  localparam int ACT_W   = 3;

  typedef enum logic [ACT_W-1:0] {
    ACT_ACTIVATE  = 3'd0,
    ACT_WRITE     = 3'd1,
    ACT_RD_LOAD   = 3'd2,
    ACT_RD_STORE  = 3'd3,
    ACT_PRE_WAIT  = 3'd4,
    ACT_PRE_EARLY = 3'd5,
    ACT_NOP       = 3'd6
  } act_e;
endpackage

// File: rtl/qsel_table.sv
module qsel_table
  import qsel_pkg::*;
#(
  parameter int STATE_W = 6,
  parameter int VAL_W   = 16,
  parameter int INIT_Q  = 4096
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [STATE_W-1:0]              rd_state,
  output logic [NUM_ACT-1:0][VAL_W-1:0]   row_o,
  input  logic [STATE_W-1:0]              pv_state,
  input  logic [ACT_W-1:0]                pv_act,
  output logic [VAL_W-1:0]                pv_val_o,
  input  logic                            wr_en,
  input  logic [VAL_W-1:0]                wr_val
);
  localparam int DEPTH = 1 << STATE_W;
  localparam logic [VAL_W-1:0] INIT_V = VAL_W'(INIT_Q);

  logic [NUM_ACT-1:0][VAL_W-1:0] mem_q [DEPTH];

  // Write port: the entry of the previous decision, enabled per decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < NUM_ACT; j++) begin
          mem_q[i][j] <= INIT_V;
        end
      end
    end else if (wr_en) begin
      mem_q[pv_state][pv_act] <= wr_val;
    end
  end

  assign row_o    = mem_q[rd_state];
  assign pv_val_o = mem_q[pv_state][pv_act];
endmodule

// File: rtl/qsel_argmax.sv
module qsel_argmax
  import qsel_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic [NUM_ACT-1:0][VAL_W-1:0] row_i,
  input  logic [NUM_ACT-1:0]            mask_i,
  output logic [ACT_W-1:0]              best_o
);
  logic                    found;
  logic signed [VAL_W-1:0] best_val;

  // Strict comparison keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    best_val = '0;
    best_o   = ACT_NOP;
    for (int i = 0; i < NUM_ACT; i++) begin
      if (mask_i[i] && (!found || $signed(row_i[i]) > best_val)) begin
        found    = 1'b1;
        best_val = $signed(row_i[i]);
        best_o   = ACT_W'(i);
      end
    end
  end
endmodule

// File: rtl/qsel_explore.sv
module qsel_explore
  import qsel_pkg::*;
#(
  parameter int          EXPLORE_BITS = 6,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic [NUM_ACT-1:0] mask_i,
  output logic               explore_o,
  output logic [ACT_W-1:0]   pick_o
);
  logic [15:0] lfsr_q, lfsr_d;
  logic [2:0]  start;

  always_comb begin
    lfsr_d = lfsr_q;
    if (step_i) lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign explore_o = (lfsr_q[EXPLORE_BITS-1:0] == '0);
  assign start     = (lfsr_q[15:13] == 3'd7) ? 3'd0 : lfsr_q[15:13];

  // First allowed action at or after the random start, wrapping
  always_comb begin
    logic done;
    int   idx;
    done   = 1'b0;
    pick_o = ACT_NOP;
    for (int k = 0; k < NUM_ACT; k++) begin
      idx = int'(start) + k;
      if (idx >= NUM_ACT) idx = idx - NUM_ACT;
      if (!done && mask_i[idx]) begin
        done   = 1'b1;
        pick_o = ACT_W'(idx);
      end
    end
  end
endmodule

// File: rtl/qsel_update.sv
module qsel_update
  import qsel_pkg::*;
#(
  parameter int VAL_W    = 16,
  parameter int FRAC_W   = 8,
  parameter int ALPHA_SH = 4,
  parameter int GAMMA_SH = 4
) (
  input  logic [ACT_W-1:0] prev_act_i,
  input  logic [VAL_W-1:0] q_old_i,
  input  logic [VAL_W-1:0] q_next_i,
  output logic [VAL_W-1:0] q_new_o
);
  localparam int EW = VAL_W + 3;
  localparam logic signed [EW-1:0] MAXV = {{(EW-VAL_W+1){1'b0}}, {(VAL_W-1){1'b1}}};
  localparam logic signed [EW-1:0] MINV = ~MAXV;
  localparam logic signed [EW-1:0] ONE  = EW'(1) <<< FRAC_W;

  logic signed [EW-1:0] qo, qn, rwd, tgt, dlt, nv;
  logic                 paid;

  assign paid = (prev_act_i == ACT_WRITE) || (prev_act_i == ACT_RD_LOAD) ||
                (prev_act_i == ACT_RD_STORE);

  always_comb begin
    qo  = {{(EW-VAL_W){q_old_i[VAL_W-1]}}, q_old_i};
    qn  = {{(EW-VAL_W){q_next_i[VAL_W-1]}}, q_next_i};
    rwd = paid ? ONE : '0;
    tgt = rwd + qn - (qn >>> GAMMA_SH);
    dlt = tgt - qo;
    nv  = qo + (dlt >>> ALPHA_SH);
    if (nv > MAXV)      q_new_o = MAXV[VAL_W-1:0];
    else if (nv < MINV) q_new_o = MINV[VAL_W-1:0];
    else                q_new_o = nv[VAL_W-1:0];
  end
endmodule

// File: rtl/qlearn_cmd_sel.sv
module qlearn_cmd_sel
  import qsel_pkg::*;
#(
  parameter int          STATE_W      = 6,
  parameter int          VAL_W        = 16,
  parameter int          FRAC_W       = 8,
  parameter int          ALPHA_SH     = 4,
  parameter int          GAMMA_SH     = 4,
  parameter int          INIT_Q       = 4096,
  parameter int          EXPLORE_BITS = 6,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [6:0]         legal_i,
  output logic               cmd_valid_o,
  output logic [2:0]         cmd_o
);
  localparam logic [NUM_ACT-1:0] NOP_BIT = NUM_ACT'(1) << (NUM_ACT - 1);

  logic [NUM_ACT-1:0]            mask_eff;
  logic [NUM_ACT-1:0][VAL_W-1:0] row;
  logic [VAL_W-1:0]              q_old, q_new;
  logic [ACT_W-1:0]              greedy_act, rand_act;
  logic                          explore;

  logic               prev_valid_q, prev_valid_d;
  logic [STATE_W-1:0] prev_state_q, prev_state_d;
  logic [ACT_W-1:0]   prev_act_q,   prev_act_d;

  assign mask_eff = legal_i | NOP_BIT;

  qsel_table #(.STATE_W(STATE_W), .VAL_W(VAL_W), .INIT_Q(INIT_Q)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_state (state_i),
    .row_o    (row),
    .pv_state (prev_state_q),
    .pv_act   (prev_act_q),
    .pv_val_o (q_old),
    .wr_en    (step_i && prev_valid_q),
    .wr_val   (q_new)
  );

  qsel_argmax #(.VAL_W(VAL_W)) u_argmax (
    .row_i  (row),
    .mask_i (mask_eff),
    .best_o (greedy_act)
  );

  qsel_explore #(.EXPLORE_BITS(EXPLORE_BITS), .LFSR_SEED(LFSR_SEED)) u_explore (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_i),
    .mask_i    (mask_eff),
    .explore_o (explore),
    .pick_o    (rand_act)
  );

  assign cmd_o       = explore ? rand_act : greedy_act;
  assign cmd_valid_o = step_i;

  qsel_update #(.VAL_W(VAL_W), .FRAC_W(FRAC_W), .ALPHA_SH(ALPHA_SH),
                .GAMMA_SH(GAMMA_SH)) u_update (
    .prev_act_i (prev_act_q),
    .q_old_i    (q_old),
    .q_next_i   (row[cmd_o]),
    .q_new_o    (q_new)
  );

  // Previous-decision record: next state
  always_comb begin
    prev_valid_d = prev_valid_q;
    prev_state_d = prev_state_q;
    prev_act_d   = prev_act_q;
    if (step_i) begin
      prev_valid_d = 1'b1;
      prev_state_d = state_i;
      prev_act_d   = cmd_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid_q <= 1'b0;
      prev_state_q <= '0;
      prev_act_q   <= ACT_NOP;
    end else begin
      prev_valid_q <= prev_valid_d;
      prev_state_q <= prev_state_d;
      prev_act_q   <= prev_act_d;
    end
  end
endmodule

// File: rtl/qlearn_cmd_sel_chk.sv
module qlearn_cmd_sel_chk #(
  parameter int STATE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step_i,
  input logic [6:0]         legal_i,
  input logic [2:0]         cmd_o,
  input logic               prev_valid,
  input logic [STATE_W-1:0] prev_state,
  input logic [2:0]         prev_act
);
  assert_cmd_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (cmd_o <= 3'd6));

  assert_cmd_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((cmd_o == 3'd6) || legal_i[cmd_o]));

  assert_nop_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && legal_i[5:0] == 6'd0) |-> (cmd_o == 3'd6));

  assert_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (prev_valid && prev_act == $past(cmd_o)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> ($stable(prev_valid) && $stable(prev_state) && $stable(prev_act)));
endmodule

bind qlearn_cmd_sel qlearn_cmd_sel_chk #(.STATE_W(STATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .step_i     (step_i),
  .legal_i    (legal_i),
  .cmd_o      (cmd_o),
  .prev_valid (prev_valid_q),
  .prev_state (prev_state_q),
  .prev_act   (prev_act_q)
);

// File: tb/qlearn_cmd_sel_tb.sv
`timescale 1ns/1ps
module qlearn_cmd_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step;
  logic [5:0] state;
  logic [6:0] legal;
  logic       cmd_valid;
  logic [2:0] cmd;

  int tests = 0;
  int fails = 0;

  // Reference model state
  int          q [64][7];
  logic [15:0] lfsr_m;
  bit          pv_valid;
  int          pv_s, pv_a;
  bit          idle_gap;

  always #2 clk = ~clk;

  qlearn_cmd_sel u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step), .state_i(state),
    .legal_i(legal), .cmd_valid_o(cmd_valid), .cmd_o(cmd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) for (int j = 0; j < 7; j++) q[i][j] = 4096;
    lfsr_m   = 16'hACE1;
    pv_valid = 0;
    pv_s     = 0;
    pv_a     = 6;
    idle_gap = 0;
  endtask

  task automatic do_step(input int s, input logic [6:0] lg, input string tag);
    logic [6:0] m;
    bit         expl;
    int         exp_a, st, qn, qo, tgt, nv, rw;
    string      req;
    @(negedge clk);
    step = 1'b1; state = 6'(s); legal = lg;
    #1;
    m     = lg | 7'h40;
    expl  = (lfsr_m[5:0] == 6'd0);
    exp_a = -1;
    if (expl) begin
      st = (lfsr_m[15:13] == 3'd7) ? 0 : int'(lfsr_m[15:13]);
      for (int k = 0; k < 7; k++) begin
        if (exp_a < 0 && m[(st + k) % 7]) exp_a = (st + k) % 7;
      end
    end else begin
      for (int i = 0; i < 7; i++) begin
        if (m[i] && (exp_a < 0 || q[s][i] > q[s][exp_a])) exp_a = i;
      end
    end
    if (lg[5:0] == 6'd0)  req = "R9 R2";
    else if (expl)        req = "R8";
    else if (!pv_valid)   req = "R4";
    else if (idle_gap)    req = "R7";
    else                  req = tag;
    check(cmd_valid === 1'b1, "R1 valid", int'(cmd_valid), 1);
    check(cmd === 3'(exp_a), req, int'(cmd), exp_a);
    // Prediction of the edge that ends this cycle
    if (pv_valid) begin
      qn  = q[s][exp_a];
      qo  = q[pv_s][pv_a];
      rw  = (pv_a >= 1 && pv_a <= 3) ? 256 : 0;
      tgt = rw + qn - (qn >>> 4);
      nv  = qo + ((tgt - qo) >>> 4);
      if (nv > 32767)  nv = 32767;
      if (nv < -32768) nv = -32768;
      q[pv_s][pv_a] = nv;
    end
    pv_valid = 1; pv_s = s; pv_a = exp_a;
    lfsr_m   = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
    idle_gap = 0;
  endtask

  task automatic do_idle();
    @(negedge clk);
    step = 1'b0; state = 6'($urandom); legal = 7'($urandom);
    #1;
    check(cmd_valid === 1'b0, "R1 idle valid", int'(cmd_valid), 0);
    idle_gap = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step = 1'b0; state = '0; legal = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check(cmd_valid === 1'b0, "R1 reset", int'(cmd_valid), 0);
    rst_n = 1'b1;

    // R4: first greedy decision after reset takes index 0
    do_step(5, 7'h7F, "R4");
    // R9 / R2: only no-operation allowed, bit 6 alone or clear
    do_step(5, 7'h00, "R9");
    do_step(5, 7'h40, "R9");
    // R3: ties among untouched entries go to the lowest allowed index
    do_step(12, 7'b0011100, "R3");
    do_step(12, 7'b0110000, "R3");
    // R5 R6: activate vs write in one state, write earns reward
    for (int n = 0; n < 40; n++) do_step(9, 7'b0000011, "R5 R6");
    check(q[9][1] > q[9][0], "R5 learned", q[9][1], q[9][0]);
    // Mixed traffic with idle gaps (R7) and exploration (R8)
    for (int n = 0; n < 4000; n++) begin
      int          s;
      logic [6:0]  lg;
      s  = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 4);
      lg = 7'($urandom);
      if ($urandom % 8 == 0) lg = lg & 7'h40;
      if ($urandom % 6 == 0) begin
        for (int g = 0; g < 1 + int'($urandom % 3); g++) do_idle();
      end
      do_step(s, lg, "R3 R5 R6");
    end
    // Reset in the middle of activity restores R4 behaviour
    @(negedge clk);
    step = 1'b0; rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    do_step(9, 7'h7F, "R4");
    do_step(9, 7'b0000110, "R3");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule